// File: doc/BRIEF.md
# Resistive Touch Screen Sampler

This block runs a resistive touch panel without processor help. It drives a four-switch panel drive matrix and picks one of four ADC sense channels. For each axis it waits a programmable settling time and then takes a power-of-two number of 12-bit conversions through a start/done handshake with an external converter. It averages each axis by summing the conversions and shifting the sum right. An averaged point outside a programmable window counts as "no touch" and is dropped. A point inside the window is reported only when it is the first one since reset, or when it has moved by more than a programmable threshold on either axis.

A report updates the two position outputs and raises a level interrupt. The interrupt stays high until software pulses the clear input. The sequencer loops forever: X phase, Y phase, evaluation, then X again.

A manual bit switches the automatic sequencer off. While it is set, the switch matrix, the sense channel and the converter start line follow software-driven inputs directly. When the bit is released, the sequencer starts a fresh round with the X phase.

Top module: `touch_sampler`

## Requirements
- R1: While reset is asserted, irq, pos_x, pos_y, sw_drive, adc_ch and adc_start are all 0.
- R2: Each axis phase holds its drive pattern for cfg_settle+1 cycles before the first conversion. The first Y start therefore appears exactly cfg_settle+2 cycles after the cycle in which the last X done was presented. Each conversion is requested by a one-cycle adc_start pulse, and no new start is issued before the previous done.
- R3: Each axis takes N = 1 << cfg_avg_log2 conversions (cfg_avg_log2 in 0..3). The axis value is the sum of those conversions shifted right by cfg_avg_log2.
- R4: A point is accepted only if both averages lie in [cfg_lo, cfg_hi], both bounds inclusive. Otherwise it is discarded: no interrupt is raised, and pos_x and pos_y keep their values.
- R5: The first accepted point after reset is always reported. After that, a point is reported only if |X - pos_x| > cfg_delta or |Y - pos_y| > cfg_delta (strict).
- R6: A report updates pos_x and pos_y and sets irq on the clock edge that follows the edge capturing the final Y done. pos_x and pos_y change at no other time.
- R7: irq is a level. It stays set until a cycle with irq_clr high. If a report and irq_clr fall on the same edge, the report wins and irq ends that edge set.
- R8: While cfg_manual is 1, sw_drive = man_drive, adc_ch = man_ch and adc_start = man_start, all combinationally. The sequencer drops its round and makes no reports. After cfg_manual returns to 0, a new round starts with the X phase.
- R9: The drive pattern {sw_drive, adc_ch} depends on cfg_wires (0: 4-wire, 1: 5-wire, 2: 7-wire, 3: 8-wire) as follows.
  - cfg_wires 0: X phase 4'b0011/ch1, Y phase 4'b1100/ch0.
  - cfg_wires 1: X phase 4'b0101/ch2, Y phase 4'b0011/ch2.
  - cfg_wires 2: X phase 4'b0111/ch1, Y phase 4'b1101/ch0.
  - cfg_wires 3: X phase 4'b0011/ch3, Y phase 4'b1100/ch2.

  Outside the phases, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_avg_log2 | input | 2 | log2 of conversions per axis |
| cfg_settle | input | 8 | Settling delay; phase waits this value plus one cycle |
| cfg_lo | input | 12 | Lowest accepted average |
| cfg_hi | input | 12 | Highest accepted average |
| cfg_delta | input | 12 | Movement threshold for a new report |
| cfg_wires | input | 2 | Panel wiring variant selecting the drive table |
| cfg_manual | input | 1 | Hands switches and converter start to software |
| man_drive | input | 4 | Software switch pattern in manual mode |
| man_ch | input | 2 | Software sense channel in manual mode |
| man_start | input | 1 | Software converter start in manual mode |
| irq_clr | input | 1 | Clears the interrupt (write-one pulse) |
| adc_done | input | 1 | Converter result valid, one cycle |
| adc_code | input | 12 | Converter result |
| sw_drive | output | 4 | Panel drive switch enables |
| adc_ch | output | 2 | Converter sense channel select |
| adc_start | output | 1 | Converter start request |
| irq | output | 1 | Level interrupt: new position reported |
| pos_x | output | 12 | Last reported X |
| pos_y | output | 12 | Last reported Y |

## Verification
Two events can meet on one edge: the evaluation that sets the interrupt, and the software clear. The bench provokes this by holding irq_clr high through a whole round while moving the Y input. It then looks at the cycle in which the new position appears and expects irq high there and low one cycle later. A second meeting is entry into manual mode on the edge where an evaluation is due. The behavioural model drops the evaluation in that case, and every clock the model is compared against irq and both positions. The behavioural model also computes averages, the inclusive window edges and the exact threshold boundary from the conversions the bench itself returns.

// File: rtl/touch_sampler.sv
module touch_sampler #(
  parameter int CODE_W   = 12,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_avg_log2,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [CODE_W-1:0]   cfg_lo,
  input  logic [CODE_W-1:0]   cfg_hi,
  input  logic [CODE_W-1:0]   cfg_delta,
  input  logic [1:0]          cfg_wires,
  input  logic                cfg_manual,
  input  logic [3:0]          man_drive,
  input  logic [1:0]          man_ch,
  input  logic                man_start,
  input  logic                irq_clr,
  input  logic                adc_done,
  input  logic [CODE_W-1:0]   adc_code,
  output logic [3:0]          sw_drive,
  output logic [1:0]          adc_ch,
  output logic                adc_start,
  output logic                irq,
  output logic [CODE_W-1:0]   pos_x,
  output logic [CODE_W-1:0]   pos_y
);
  localparam int ACC_W = CODE_W + 3;

  typedef enum logic [2:0] {ST_IDLE, ST_SETTLE, ST_REQ, ST_WAIT, ST_EVAL} st_t;

  st_t                 state;
  logic                axis_y;
  logic [SETTLE_W-1:0] cnt;
  logic [2:0]          nsamp;
  logic [ACC_W-1:0]    acc_x;
  logic [ACC_W-1:0]    acc_y;
  logic                have_pos;

  logic [2:0]          n_last;
  logic [CODE_W-1:0]   avg_x;
  logic [CODE_W-1:0]   avg_y;
  logic [CODE_W-1:0]   dx;
  logic [CODE_W-1:0]   dy;
  logic                in_win;
  logic                moved;
  logic                active;
  logic [3:0]          auto_drive;
  logic [1:0]          auto_ch;

  assign n_last = 3'((4'd1 << cfg_avg_log2) - 4'd1);
  assign avg_x  = CODE_W'(acc_x >> cfg_avg_log2);
  assign avg_y  = CODE_W'(acc_y >> cfg_avg_log2);
  assign dx     = (avg_x >= pos_x) ? avg_x - pos_x : pos_x - avg_x;
  assign dy     = (avg_y >= pos_y) ? avg_y - pos_y : pos_y - avg_y;
  assign in_win = (avg_x >= cfg_lo) && (avg_x <= cfg_hi) &&
                  (avg_y >= cfg_lo) && (avg_y <= cfg_hi);
  assign moved  = !have_pos || (dx > cfg_delta) || (dy > cfg_delta);
  assign active = (state == ST_SETTLE) || (state == ST_REQ) || (state == ST_WAIT);

  always_comb begin
    auto_drive = '0;
    auto_ch    = '0;
    if (active) begin
      case (cfg_wires)
        2'd0:    {auto_drive, auto_ch} = axis_y ? {4'b1100, 2'd0} : {4'b0011, 2'd1};
        2'd1:    {auto_drive, auto_ch} = axis_y ? {4'b0011, 2'd2} : {4'b0101, 2'd2};
        2'd2:    {auto_drive, auto_ch} = axis_y ? {4'b1101, 2'd0} : {4'b0111, 2'd1};
        default: {auto_drive, auto_ch} = axis_y ? {4'b1100, 2'd2} : {4'b0011, 2'd3};
      endcase
    end
  end

  assign sw_drive  = cfg_manual ? man_drive : auto_drive;
  assign adc_ch    = cfg_manual ? man_ch    : auto_ch;
  assign adc_start = cfg_manual ? man_start : (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      axis_y   <= 1'b0;
      cnt      <= '0;
      nsamp    <= '0;
      acc_x    <= '0;
      acc_y    <= '0;
      have_pos <= 1'b0;
      irq      <= 1'b0;
      pos_x    <= '0;
      pos_y    <= '0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (cfg_manual) begin
        state  <= ST_IDLE;
        axis_y <= 1'b0;
        cnt    <= '0;
        nsamp  <= '0;
        acc_x  <= '0;
        acc_y  <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            state  <= ST_SETTLE;
            axis_y <= 1'b0;
            cnt    <= '0;
            nsamp  <= '0;
            acc_x  <= '0;
            acc_y  <= '0;
          end
          ST_SETTLE: begin
            if (cnt == cfg_settle) begin
              state <= ST_REQ;
              cnt   <= '0;
            end else begin
              cnt <= cnt + SETTLE_W'(1);
            end
          end
          ST_REQ: state <= ST_WAIT;
          ST_WAIT: begin
            if (adc_done) begin
              if (axis_y) acc_y <= acc_y + {3'b000, adc_code};
              else        acc_x <= acc_x + {3'b000, adc_code};
              if (nsamp == n_last) begin
                nsamp <= '0;
                if (axis_y) begin
                  state <= ST_EVAL;
                end else begin
                  axis_y <= 1'b1;
                  cnt    <= '0;
                  state  <= ST_SETTLE;
                end
              end else begin
                nsamp <= nsamp + 3'd1;
                state <= ST_REQ;
              end
            end
          end
          ST_EVAL: begin
            if (in_win && moved) begin
              pos_x    <= avg_x;
              pos_y    <= avg_y;
              have_pos <= 1'b1;
              irq      <= 1'b1;
            end
            acc_x  <= '0;
            acc_y  <= '0;
            axis_y <= 1'b0;
            cnt    <= '0;
            state  <= ST_SETTLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_manual && adc_start) |=> (cfg_manual || !adc_start));

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  assert_pos_with_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pos_x) || !$stable(pos_y)) |-> irq);

  assert_report_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (pos_x >= cfg_lo && pos_x <= cfg_hi && pos_y >= cfg_lo && pos_y <= cfg_hi));

  assert_manual_no_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_manual |=> ($stable(pos_x) && $stable(pos_y)));

  assert_drive_on_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_manual && adc_start) |-> (sw_drive != 4'b0000));
endmodule

// File: tb/sim_touch_sampler.sv
module sim_touch_sampler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_avg_log2 = 2'd2;
  logic [7:0]  cfg_settle = 8'd3;
  logic [11:0] cfg_lo = 12'd100;
  logic [11:0] cfg_hi = 12'd3900;
  logic [11:0] cfg_delta = 12'd20;
  logic [1:0]  cfg_wires = 2'd0;
  logic        cfg_manual = 1'b0;
  logic [3:0]  man_drive = 4'd0;
  logic [1:0]  man_ch = 2'd0;
  logic        man_start = 1'b0;
  logic        irq_clr = 1'b0;
  logic        adc_done = 1'b0;
  logic [11:0] adc_code = 12'd0;
  logic [3:0]  sw_drive;
  logic [1:0]  adc_ch;
  logic        adc_start;
  logic        irq;
  logic [11:0] pos_x;
  logic [11:0] pos_y;

  touch_sampler u0 (
    .clk(clk), .rst_n(rst_n), .cfg_avg_log2(cfg_avg_log2), .cfg_settle(cfg_settle),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_delta(cfg_delta), .cfg_wires(cfg_wires),
    .cfg_manual(cfg_manual), .man_drive(man_drive), .man_ch(man_ch), .man_start(man_start),
    .irq_clr(irq_clr), .adc_done(adc_done), .adc_code(adc_code), .sw_drive(sw_drive),
    .adc_ch(adc_ch), .adc_start(adc_start), .irq(irq), .pos_x(pos_x), .pos_y(pos_y)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int base_x = 1000;
  int base_y = 2000;
  int sum_x = 0, sum_y = 0;
  int ridx = 0, pend = 0, cyc = 0, t_xdone = 0;
  bit done_last = 0;
  bit m_irq = 0, m_have = 0, m_pend = 0;
  int m_x = 0, m_y = 0, m_evals = 0;

  function automatic int table_of(input int w, input bit y);
    case (w)
      0:       return y ? ((4'b1100 << 2) | 0) : ((4'b0011 << 2) | 1);
      1:       return y ? ((4'b0011 << 2) | 2) : ((4'b0101 << 2) | 2);
      2:       return y ? ((4'b1101 << 2) | 0) : ((4'b0111 << 2) | 1);
      default: return y ? ((4'b1100 << 2) | 2) : ((4'b0011 << 2) | 3);
    endcase
  endfunction

  // converter responder: two cycles of latency, a known code per sample
  always @(posedge clk) begin
    #5;
    cyc++;
    if (!rst_n || cfg_manual) begin
      pend = 0; adc_done = 1'b0; ridx = 0; done_last = 0;
    end else begin
      int n;
      n = 1 << cfg_avg_log2;
      adc_done = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          int code;
          code = ((ridx < n) ? base_x : base_y) + (ridx % n);
          adc_code = 12'(code);
          adc_done = 1'b1;
          if (ridx < n) sum_x += code; else sum_y += code;
          done_last = (ridx == 2*n - 1);
          if (ridx == n - 1) t_xdone = cyc;
          ridx = (ridx + 1) % (2*n);
        end
      end
      if (adc_start) begin
        chk(pend == 0 && !adc_done, "R2 start while busy", pend, 0);
        chk({sw_drive, adc_ch} == 6'(table_of(cfg_wires, ridx >= n)), "R9 drive/channel",
            {sw_drive, adc_ch}, table_of(cfg_wires, ridx >= n));
        if (ridx == n) chk(cyc - t_xdone == cfg_settle + 2, "R2 settle gap", cyc - t_xdone, cfg_settle + 2);
        pend = 2;
      end
    end
  end

  // behavioural reference of reports and interrupt (R3 R4 R5 R6 R7)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_irq = 0; m_have = 0; m_pend = 0; m_x = 0; m_y = 0; sum_x = 0; sum_y = 0;
    end else begin
      bit fire;
      fire = 0;
      if (cfg_manual) begin
        m_pend = 0; sum_x = 0; sum_y = 0;
      end else if (m_pend) begin
        int ax, ay, ddx, ddy;
        m_pend = 0;
        ax = sum_x >> cfg_avg_log2;
        ay = sum_y >> cfg_avg_log2;
        ddx = (ax > m_x) ? ax - m_x : m_x - ax;
        ddy = (ay > m_y) ? ay - m_y : m_y - ay;
        if (ax >= cfg_lo && ax <= cfg_hi && ay >= cfg_lo && ay <= cfg_hi &&
            (!m_have || ddx > cfg_delta || ddy > cfg_delta)) begin
          m_x = ax; m_y = ay; m_have = 1; fire = 1;
        end
        sum_x = 0; sum_y = 0;
        m_evals++;
      end else if (adc_done && done_last) begin
        m_pend = 1;
      end
      if (fire) m_irq = 1;
      else if (irq_clr) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    #5;
    if (rst_n && !ended) begin
      chk(irq == m_irq, "R7 irq vs model", irq, m_irq);
      chk(pos_x == 12'(m_x), "R6 pos_x vs model", pos_x, m_x);
      chk(pos_y == 12'(m_y), "R6 pos_y vs model", pos_y, m_y);
      if (cfg_manual) begin
        chk(sw_drive == man_drive, "R8 drive pass-through", sw_drive, man_drive);
        chk(adc_ch == man_ch, "R8 channel pass-through", adc_ch, man_ch);
        chk(adc_start == man_start, "R8 start pass-through", adc_start, man_start);
      end
    end
  end

  task automatic wait_evals(input int n);
    int target;
    target = m_evals + n;
    while (m_evals < target) @(negedge clk);
    #5;
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk({irq, pos_x, pos_y, sw_drive, adc_ch, adc_start} == '0, "R1 reset state",
        {irq, sw_drive, adc_ch, adc_start}, 0);
    @(negedge clk) rst_n = 1'b1;

    wait_evals(1);
    chk(pos_x == 1001 && pos_y == 2001, "R3 first average", pos_x, 1001);
    chk(irq == 1, "R6 first report irq", irq, 1);
    wait_evals(2);
    chk(irq == 1, "R7 irq held", irq, 1);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    #5 chk(irq == 0, "R7 cleared", irq, 0);

    base_x = 1015; wait_evals(3);
    chk(irq == 0 && pos_x == 1001, "R5 small move ignored", pos_x, 1001);
    base_x = 1020; wait_evals(3);
    chk(irq == 0 && pos_x == 1001, "R5 move equal to threshold ignored", pos_x, 1001);
    base_x = 1021; wait_evals(3);
    chk(irq == 1 && pos_x == 1022, "R5 move above threshold", pos_x, 1022);

    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    base_x = 50; wait_evals(3);
    chk(irq == 0 && pos_x == 1022, "R4 below window discarded", pos_x, 1022);
    base_x = 99; wait_evals(3);
    chk(pos_x == 100, "R4 low bound inclusive", pos_x, 100);

    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk);
    base_y = 2500;
    for (int k = 0; k < 4; k++) begin
      int prev;
      prev = pos_y;
      wait_evals(1);
      if (pos_y != 12'(prev)) begin
        chk(irq == 1, "R7 report wins over clear", irq, 1);
        @(negedge clk);
        #5 chk(irq == 0, "R7 clear next cycle", irq, 0);
        break;
      end
    end
    @(negedge clk) irq_clr = 1'b0;

    for (int w = 1; w < 4; w++) begin
      @(negedge clk) cfg_wires = 2'(w);
      wait_evals(2);
    end
    chk(1, "R9 wiring variants exercised", 1, 1);

    @(negedge clk) begin
      cfg_manual = 1'b1; man_drive = 4'b1010; man_ch = 2'd3; man_start = 1'b1;
    end
    #5 chk(sw_drive == 4'b1010 && adc_ch == 3 && adc_start == 1, "R8 manual outputs", sw_drive, 10);
    begin
      int ev, px;
      ev = m_evals; px = pos_x;
      base_x = 3000; base_y = 1500;
      repeat (100) @(negedge clk);
      #5 chk(pos_x == 12'(px) && m_evals == ev, "R8 no reports in manual", pos_x, px);
    end
    cfg_avg_log2 = 2'd0;
    @(negedge clk) begin man_start = 1'b0; cfg_manual = 1'b0; end
    wait_evals(2);
    chk(pos_x == 3000 && pos_y == 1500, "R3 single sample", pos_x, 3000);

    base_y = 3900; wait_evals(2);
    chk(pos_y == 3900, "R4 high bound inclusive", pos_y, 3900);
    base_y = 3901; base_x = 500; wait_evals(2);
    chk(pos_y == 3900 && pos_x == 3000, "R4 above window discarded", pos_x, 3000);

    @(negedge clk) cfg_manual = 1'b1;
    @(negedge clk) cfg_avg_log2 = 2'd3;
    base_x = 2000; base_y = 2000;
    @(negedge clk) cfg_manual = 1'b0;
    wait_evals(2);
    chk(pos_x == 2003 && pos_y == 2003, "R3 eight samples", pos_x, 2003);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule